// File: doc/BRIEF.md
# Memory-Mapped Serial Flash Read Engine

This block lets a processor execute and load straight from a serial NOR flash on the first chip select. A word read on the local bus becomes one SPI read transaction. The transaction sends the read opcode and a 24-bit flash address, then clocks in four data bytes. The engine returns them as one big-endian 32-bit word. The bus window is 16 MiB. After reset only the lowest 4 MiB of flash is visible, and it repeats four times across the window. A control bit opens the whole 16 MiB.

Writes on the same bus always reach a small register set. A write to the mode-select word at offset 0 takes the pins away from the read engine and gives them to software. From then on software drives chip selects, clock and data out through an I/O register. It collects the input line in a shift register. Only reset returns the block to mapped mode.

Top module: `spi_xip_rd`

## Requirements
- R1: After reset `ready_o` is low, all three chip selects are high (inactive), `spi_sck_o` is high and the block is in mapped mode.
- R2: A mapped read drives only `spi_cs_no[0]` low. On `spi_mosi_o` it sends the opcode 0x03 and then the 24-bit flash address, most significant bit first. Every bit is stable at the rising edge of `spi_sck_o`.
- R3: While the remap-disable bit is 0, the flash address is `{2'b00, addr_i[21:2], 2'b00}`. Bus address bits 23:22 and 1:0 are ignored.
- R4: Bit 0 of a write to offset 4 sets the remap-disable bit. When it is 1, the flash address is `{addr_i[23:2], 2'b00}`. Writing 0 restores the aliasing.
- R5: The 32 bits sampled from `spi_miso_i` after the address fill `rdata_o` MSB first. The first received byte lands in bits 31:24.
- R6: A mapped read makes exactly 64 rising SCK edges. `ready_o` is a one-cycle pulse, 64*CLK_DIV+1 clock edges after the edge that accepted the request. `spi_cs_no[0]` is already high when `ready_o` rises.
- R7: The link runs in mode 3. SCK is high whenever the chip select is inactive.
- R8: In mapped mode `spi_cs_no[2:1]` are never driven low.
- R9: A write of any value to offset 0 enters register mode permanently. In register mode, I/O register (offset 8) bit 0 drives `spi_mosi_o`, bit 1 drives `spi_sck_o`, and bits 4:2 drive `spi_cs_no[2:0]`.
- R10: In register mode, each write to offset 8 that changes the SCK bit from 0 to 1 shifts `spi_miso_i` into bit 0 of a 32-bit shift register. A read of offset 12 returns that register.
- R11: In register mode, a read at an offset other than 12 starts no SPI transaction. It returns 0 with `ready_o` one edge after acceptance.
- R12: Every write completes with `ready_o` one edge after acceptance.
- R13: In mapped mode, a write to the I/O register leaves the pins unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request, held until `ready_o` |
| we_i | input | 1 | 1 = register write, 0 = read |
| addr_i | input | 24 | Byte address in the window; bits 3:2 select a register |
| wdata_i | input | 32 | Write data |
| ready_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 32 | Read data, valid with `ready_o` |
| spi_sck_o | output | 1 | Serial clock, idles high |
| spi_mosi_o | output | 1 | Serial data to flash |
| spi_cs_no | output | 3 | Active-low chip selects |
| spi_miso_i | input | 1 | Serial data from flash |

## Verification
A mapped read raises `ready_o` 64*CLK_DIV+1 edges after the accepting edge. With the bench driving on the falling clock edge, that is the 64*CLK_DIV+2-th falling edge after the request is driven. Writes and register-mode reads finish on the first falling edge. The bench counts falling edges from the request to `ready_o` and checks that count exactly for every access. All pin, data and flash-side checks are taken on that same falling edge or later. The flash-side command, address and rising-edge count come from a behavioural flash model fed by the pins.

// File: rtl/spi_xip_pkg.sv
package spi_xip_pkg;
  localparam logic [7:0] RD_OPCODE = 8'h03;
  localparam int CMD_W = 8;
  localparam int CS_NUM = 3;
  // I/O register layout: mosi, sck, then one bit per chip select
  localparam int IO_MOSI = 0;
  localparam int IO_SCK = 1;
  localparam int IO_CS_LSB = 2;
  localparam int IO_W = IO_CS_LSB + CS_NUM;
  localparam logic [IO_W-1:0] IO_RST = {{CS_NUM{1'b1}}, 1'b1, 1'b0};

  typedef enum logic [1:0] {
    OFS_FSEL  = 2'd0,
    OFS_CTRL  = 2'd1,
    OFS_IOCTL = 2'd2,
    OFS_RDATA = 2'd3
  } reg_ofs_e;

  typedef enum logic [1:0] {
    BS_IDLE,
    BS_XFER,
    BS_DONE
  } bus_state_e;
endpackage

// File: rtl/spi_xip_amap.sv
module spi_xip_amap #(
  parameter int WIN_W  = 24,
  parameter int BOOT_W = 22
) (
  input  logic [WIN_W-3:0] word_addr_i,
  input  logic             remap_dis_i,
  output logic [WIN_W-1:0] flash_addr_o
);
  localparam int HI_W = WIN_W - BOOT_W;

  generate
    if (HI_W == 0) begin : g_flat
      logic unused_remap;
      assign unused_remap = remap_dis_i;
      assign flash_addr_o = {word_addr_i, 2'b00};
    end else begin : g_alias
      // boot window repeats until remap is disabled
      assign flash_addr_o = remap_dis_i ? {word_addr_i, 2'b00}
                                        : {{HI_W{1'b0}}, word_addr_i[BOOT_W-3:0], 2'b00};
    end
  endgenerate
endmodule

// File: rtl/spi_xip_seq.sv
module spi_xip_seq import spi_xip_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int WIN_W   = 24,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WIN_W-1:0]  addr_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] data_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              cs_n_o
);
  localparam int LO_CYC   = CLK_DIV / 2;
  localparam int HI_CYC   = CLK_DIV - LO_CYC;
  localparam int TOT_BITS = CMD_W + WIN_W + DATA_W;
  localparam int TX_W     = CMD_W + WIN_W;
  localparam int CNT_W    = $clog2(CLK_DIV + 1);
  localparam int BIT_W    = $clog2(TOT_BITS + 1);

  logic              busy_q, phase_hi_q, done_q;
  logic              sck_q, mosi_q, cs_n_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bits_q;
  logic [TX_W-1:0]   tx_q;
  logic [DATA_W-1:0] rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      phase_hi_q <= 1'b0;
      done_q     <= 1'b0;
      sck_q      <= 1'b1;
      mosi_q     <= 1'b0;
      cs_n_q     <= 1'b1;
      cnt_q      <= '0;
      bits_q     <= '0;
      tx_q       <= '0;
      rx_q       <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q     <= 1'b1;
          cs_n_q     <= 1'b0;
          sck_q      <= 1'b0;
          phase_hi_q <= 1'b0;
          cnt_q      <= CNT_W'(LO_CYC - 1);
          bits_q     <= '0;
          mosi_q     <= RD_OPCODE[CMD_W-1];
          tx_q       <= {RD_OPCODE[CMD_W-2:0], addr_i, 1'b0};
        end
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end else if (!phase_hi_q) begin
        // rising edge: sample input
        sck_q      <= 1'b1;
        phase_hi_q <= 1'b1;
        cnt_q      <= CNT_W'(HI_CYC - 1);
        rx_q       <= {rx_q[DATA_W-2:0], miso_i};
        bits_q     <= bits_q + 1'b1;
      end else if (bits_q == BIT_W'(TOT_BITS)) begin
        busy_q <= 1'b0;
        cs_n_q <= 1'b1;
        done_q <= 1'b1;
      end else begin
        // falling edge: launch next bit
        sck_q      <= 1'b0;
        phase_hi_q <= 1'b0;
        cnt_q      <= CNT_W'(LO_CYC - 1);
        mosi_q     <= tx_q[TX_W-1];
        tx_q       <= {tx_q[TX_W-2:0], 1'b0};
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign data_o = rx_q;
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;
  assign cs_n_o = cs_n_q;

  // R7
  mosi_setup_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sck_o) |-> $stable(mosi_o));
  // R7
  sck_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_o |-> sck_o);
  // R6
  bit_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (bits_q <= BIT_W'(TOT_BITS)));
endmodule

// File: rtl/spi_xip_regs.sv
module spi_xip_regs import spi_xip_pkg::*; #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  reg_ofs_e          wr_ofs_i,
  input  logic [IO_W-1:0]   wr_data_i,
  input  logic              miso_i,
  output logic              reg_mode_o,
  output logic              remap_dis_o,
  output logic [IO_W-1:0]   io_o,
  output logic [DATA_W-1:0] shift_o
);
  logic              reg_mode_q, remap_q;
  logic [IO_W-1:0]   io_q;
  logic [DATA_W-1:0] shift_q;
  logic              sck_rise;

  assign sck_rise = reg_mode_q && wr_data_i[IO_SCK] && !io_q[IO_SCK];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_mode_q <= 1'b0;
      remap_q    <= 1'b0;
      io_q       <= IO_RST;
      shift_q    <= '0;
    end else if (wr_en_i) begin
      unique case (wr_ofs_i)
        OFS_FSEL:  reg_mode_q <= 1'b1;
        OFS_CTRL:  remap_q    <= wr_data_i[0];
        OFS_IOCTL: begin
          io_q <= wr_data_i;
          if (sck_rise) shift_q <= {shift_q[DATA_W-2:0], miso_i};
        end
        default: ;
      endcase
    end
  end

  assign reg_mode_o  = reg_mode_q;
  assign remap_dis_o = remap_q;
  assign io_o        = io_q;
  assign shift_o     = shift_q;

  // R9
  fsel_enter_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ofs_i == OFS_FSEL) |=> reg_mode_o);
  // R9
  mode_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_mode_o |=> reg_mode_o);
  // R10
  shift_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_ofs_i == OFS_IOCTL && reg_mode_o && wr_data_i[IO_SCK] && !io_o[IO_SCK])
    |=> shift_o[0] == $past(miso_i));
  // R10
  shift_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(shift_o));
endmodule

// File: rtl/spi_xip_rd.sv
module spi_xip_rd import spi_xip_pkg::*; #(
  parameter int CLK_DIV = 4,
  parameter int WIN_W   = 24,
  parameter int BOOT_W  = 22,
  parameter int DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [WIN_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              ready_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              spi_sck_o,
  output logic              spi_mosi_o,
  output logic [CS_NUM-1:0] spi_cs_no,
  input  logic              spi_miso_i
);
  bus_state_e        state_q;
  reg_ofs_e          ofs;
  logic              accept, seq_start, reg_wr;
  logic              reg_mode, remap_dis;
  logic [IO_W-1:0]   io_q;
  logic [DATA_W-1:0] shift_q, seq_data, rdata_q;
  logic              seq_busy, seq_done, seq_sck, seq_mosi, seq_cs_n;
  logic [WIN_W-1:0]  flash_addr;
  logic              unused_bits;

  assign ofs         = reg_ofs_e'(addr_i[3:2]);
  assign accept      = (state_q == BS_IDLE) && req_i;
  assign reg_wr      = accept && we_i;
  assign seq_start   = accept && !we_i && !reg_mode;
  assign unused_bits = ^{addr_i[1:0], wdata_i[DATA_W-1:IO_W], seq_busy};

  spi_xip_amap #(.WIN_W(WIN_W), .BOOT_W(BOOT_W)) amap_i (
    .word_addr_i (addr_i[WIN_W-1:2]),
    .remap_dis_i (remap_dis),
    .flash_addr_o(flash_addr)
  );

  spi_xip_regs #(.DATA_W(DATA_W)) regs_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (reg_wr),
    .wr_ofs_i   (ofs),
    .wr_data_i  (wdata_i[IO_W-1:0]),
    .miso_i     (spi_miso_i),
    .reg_mode_o (reg_mode),
    .remap_dis_o(remap_dis),
    .io_o       (io_q),
    .shift_o    (shift_q)
  );

  spi_xip_seq #(.CLK_DIV(CLK_DIV), .WIN_W(WIN_W), .DATA_W(DATA_W)) seq_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(seq_start),
    .addr_i (flash_addr),
    .miso_i (spi_miso_i),
    .busy_o (seq_busy),
    .done_o (seq_done),
    .data_o (seq_data),
    .sck_o  (seq_sck),
    .mosi_o (seq_mosi),
    .cs_n_o (seq_cs_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= BS_IDLE;
      rdata_q <= '0;
    end else begin
      unique case (state_q)
        BS_IDLE: if (req_i) begin
          if (we_i) begin
            state_q <= BS_DONE;
          end else if (reg_mode) begin
            rdata_q <= (ofs == OFS_RDATA) ? shift_q : '0;
            state_q <= BS_DONE;
          end else begin
            state_q <= BS_XFER;
          end
        end
        BS_XFER: if (seq_done) begin
          rdata_q <= seq_data;
          state_q <= BS_DONE;
        end
        default: state_q <= BS_IDLE;
      endcase
    end
  end

  assign ready_o    = (state_q == BS_DONE);
  assign rdata_o    = rdata_q;
  assign spi_sck_o  = reg_mode ? io_q[IO_SCK]  : seq_sck;
  assign spi_mosi_o = reg_mode ? io_q[IO_MOSI] : seq_mosi;

  generate
    for (genvar c = 0; c < CS_NUM; c++) begin : g_cs
      if (c == 0) begin : g_boot
        assign spi_cs_no[c] = reg_mode ? io_q[IO_CS_LSB+c] : seq_cs_n;
      end else begin : g_aux
        assign spi_cs_no[c] = reg_mode ? io_q[IO_CS_LSB+c] : 1'b1;
      end
    end
  endgenerate

  // R6
  ready_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> !ready_o);
  // R6
  done_cs_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && !reg_mode) |-> spi_cs_no[0]);
  // R8
  aux_cs_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_mode |-> (&spi_cs_no[CS_NUM-1:1]));
  // R11
  no_xfer_in_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_mode |-> !seq_busy);
endmodule

// File: tb/spi_xip_rd_tb.sv
module spi_xip_rd_tb_top;
  localparam int DIV = 4;
  localparam int MAP_LAT = 64 * DIV + 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        ready;
  logic [31:0] rdata;
  logic        sck, mosi, miso, tb_miso = 1'b0;
  logic [2:0]  cs_n;

  int n_chk = 0, n_fail = 0;
  bit reg_mode_tb = 1'b0;
  bit aux_bad = 1'b0;

  int          fl_cnt = 0;
  logic [31:0] fl_cmd = '0;
  logic        fl_miso = 1'b0;

  always #10ns clk = ~clk;

  spi_xip_rd #(.CLK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .ready_o(ready), .rdata_o(rdata), .spi_sck_o(sck),
    .spi_mosi_o(mosi), .spi_cs_no(cs_n), .spi_miso_i(miso)
  );

  assign miso = cs_n[0] ? tb_miso : fl_miso;

  function automatic logic [7:0] fbyte(input logic [23:0] a);
    return (a[7:0] + a[15:8] * 8'd7 + a[23:16] * 8'd13) ^ 8'h5A;
  endfunction

  function automatic logic [23:0] exp_fa(input logic [23:0] a, input bit remap);
    return remap ? {a[23:2], 2'b00} : {2'b00, a[21:2], 2'b00};
  endfunction

  function automatic logic [31:0] exp_word(input logic [23:0] fa);
    return {fbyte(fa), fbyte(fa + 24'd1), fbyte(fa + 24'd2), fbyte(fa + 24'd3)};
  endfunction

  // behavioural flash on chip select 0
  always @(negedge cs_n[0]) fl_cnt = 0;
  always @(posedge sck) if (!cs_n[0]) begin
    if (fl_cnt < 32) fl_cmd = {fl_cmd[30:0], mosi};
    fl_cnt = fl_cnt + 1;
  end
  always @(negedge sck) if (!cs_n[0] && fl_cnt >= 32) begin
    int k;
    logic [7:0] b;
    k = fl_cnt - 32;
    b = fbyte(fl_cmd[23:0] + 24'(k / 8));
    fl_miso = b[7 - (k % 8)];
  end

  always @(posedge clk)
    if (rst_n && !reg_mode_tb && (cs_n[1] !== 1'b1 || cs_n[2] !== 1'b1)) aux_bad = 1'b1;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_op(input logic w, input logic [23:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    req = 1'b1; we = w; addr = a; wdata = d; lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!ready && lat < 4000);
    rd = rdata;
    req = 1'b0;
  endtask

  task automatic map_read(input logic [23:0] a, input bit remap, input string tag);
    logic [31:0] rd;
    int lat;
    logic [23:0] fa;
    fa = exp_fa(a, remap);
    bus_op(1'b0, a, '0, rd, lat);
    check({"R6 latency ", tag}, lat, MAP_LAT);
    check({"R2 opcode ", tag}, {24'd0, fl_cmd[31:24]}, 32'h03);
    check({"R3/R4 flash address ", tag}, {8'd0, fl_cmd[23:0]}, {8'd0, fa});
    check({"R5 data ", tag}, rd, exp_word(fa));
    check({"R6 sck rises ", tag}, fl_cnt, 64);
    check({"R6 cs released ", tag}, {29'd0, cs_n}, 32'd7);
  endtask

  task automatic wr(input logic [23:0] a, input logic [31:0] d, input string tag);
    logic [31:0] rd;
    int lat;
    bus_op(1'b1, a, d, rd, lat);
    check({"R12 write latency ", tag}, lat, 1);
  endtask

  initial begin
    logic [31:0] rd;
    int lat;
    logic [7:0] pat;
    bit remap;
    logic [23:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 ready", {31'd0, ready}, 0);
    check("R1 cs", {29'd0, cs_n}, 7);
    check("R1 sck idle high (R7)", {31'd0, sck}, 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 sck idle after reset", {31'd0, sck}, 1);

    // R3 aliasing, directed corners
    map_read(24'h000000, 1'b0, "base");
    map_read(24'hC00004, 1'b0, "alias top");
    map_read(24'h7FFFFF, 1'b0, "alias low bits");
    // R4 full window
    wr(24'h000004, 32'h1, "ctrl");
    map_read(24'hC00004, 1'b1, "remap top");
    map_read(24'hFFFFFC, 1'b1, "remap end");

    // constrained random mix of remap and addresses
    for (int i = 0; i < 16; i++) begin
      remap = 1'($urandom % 2);
      a = 24'($urandom);
      wr(24'h000004, {31'd0, remap}, "ctrl rand");
      map_read(a, remap, "rand");
    end

    // R13 I/O register ignored in mapped mode
    wr(24'h000008, 32'h0, "io mapped");
    check("R13 cs unchanged", {29'd0, cs_n}, 7);
    check("R13 sck unchanged", {31'd0, sck}, 1);
    map_read(24'h123456, 1'b0, "after io write");
    wr(24'h000008, 32'h1E, "io restore");

    // R9 enter register mode
    reg_mode_tb = 1'b1;
    wr(24'h000000, 32'h0, "fsel");
    check("R9 pins follow io cs", {29'd0, cs_n}, 7);
    check("R9 pins follow io sck", {31'd0, sck}, 1);
    wr(24'h000008, 32'h16, "io cs1");
    check("R9 cs1 low", {29'd0, cs_n}, 3'b101);

    // R10 bit-bang a byte into the shift register
    pat = 8'($urandom);
    for (int i = 7; i >= 0; i--) begin
      wr(24'h000008, {27'd0, 3'b101, 1'b0, pat[i]}, "io low");
      check("R9 mosi follows io", {31'd0, mosi}, {31'd0, pat[i]});
      check("R9 sck low", {31'd0, sck}, 0);
      tb_miso = pat[i];
      wr(24'h000008, {27'd0, 3'b101, 1'b1, pat[i]}, "io high");
    end
    bus_op(1'b0, 24'h00000C, '0, rd, lat);
    check("R10 shift data", rd, {24'd0, pat});
    check("R11 reg read latency", lat, 1);

    // R11 other offset in register mode
    bus_op(1'b0, 24'h000004, '0, rd, lat);
    check("R11 zero data", rd, 0);
    check("R11 latency", lat, 1);
    check("R11 no transfer cs", {29'd0, cs_n}, 3'b101);
    check("R11 no transfer sck", {31'd0, sck}, 1);
    wr(24'h000000, 32'h1, "fsel one");
    check("R9 stays in register mode", {29'd0, cs_n}, 3'b101);

    check("R8 aux chip selects idle in mapped mode", {31'd0, aux_bad}, 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule